// File: doc/BRIEF.md
# PLL Loop Bandwidth Mode Register

This block is an 8-bit control and status register in a clock generator. It chooses whether the PLL loop filter bandwidth is set by hardware or by software. Software reaches it through a simple synchronous bus port. The PLL supplies two flags: a lock-detect flag, and an acquisition/tracking status flag from the automatic bandwidth logic. The block drives two signals into the loop filter. One is the automatic-mode enable. The other is the acquisition/tracking select.

A two-state machine holds the mode. The states are `MODE_MANUAL`, which is the reset state, and `MODE_AUTO`. A register write with bit 7 set takes the transition `MAN_TO_AUTO`. A register write with bit 7 clear takes the transition `AUTO_TO_MAN`. Every other cycle holds the current state.

In manual mode, bit 5 is an ordinary read/write bit and directly selects acquisition (0) or tracking (1). In automatic mode, bit 5 and the lock bit become read-only views of the PLL flags. The value software last chose is held in a shadow flop during automatic mode, and it drives the select again once manual mode returns.

Top module: `pbw_ctrl_reg`

## Requirements
- R1: After reset, `auto_en_o` is 0, `trk_sel_o` is 0 (acquisition), and a register read returns 8'h00.
- R2: Bits 4 down to 0 of every read return 0, whatever was written to them.
- R3: A register write with bit 7 = 1 sets `auto_en_o`, and one with bit 7 = 0 clears it. The output changes on the clock edge that takes the write.
- R4: Read bit 6 (lock) equals `pll_lock_i` while `auto_en_o` is 1, and reads 0 while `auto_en_o` is 0.
- R5: The value written to bit 6 has no effect on any read or output.
- R6: While `auto_en_o` is 1, read bit 5 and `trk_sel_o` both equal `auto_trk_i` (1 = tracking, 0 = acquisition).
- R7: While `auto_en_o` is 0, a register write stores bit 5. From the next edge on, `trk_sel_o` and read bit 5 show that value. This includes the write that sets bit 7 to enter automatic mode.
- R8: Writes made while `auto_en_o` is 1 do not change the stored bit 5. When automatic mode is cleared, `trk_sel_o` and read bit 5 return to the value last stored in manual mode.
- R9: A bus cycle counts as a register write only when `bus_cs`=1, `bus_we`=1 and `bus_addr` equals `REG_ADDR`. Any other bus cycle leaves the state unchanged. A read returns the register value only when `bus_cs`=1, `bus_we`=0 and the address matches; otherwise it returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus chip select |
| bus_we | input | 1 | Bus write enable (1 = write, 0 = read) |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pll_lock_i | input | 1 | PLL lock-detect flag |
| auto_trk_i | input | 1 | Tracking status from the automatic bandwidth logic |
| auto_en_o | output | 1 | Automatic bandwidth enable to the loop filter |
| trk_sel_o | output | 1 | Acquisition (0) / tracking (1) select to the loop filter |

## Verification
The bench builds the block with `ADDR_W` = 6 and `REG_ADDR` = 6'h15, rather than the 8-bit default. This puts a neighbouring address (6'h14), which differs only in bit 0, within reach of the decode checks. It also exercises the address comparator at a width other than the data width. The bench drives the PLL flags opposite to the shadow value, so that a select output taken from the wrong source shows up as a mismatch. It then runs two separate automatic episodes that end with different restored values.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

    localparam int REG_W    = 8;
    localparam int BIT_AUTO = 7;
    localparam int BIT_LOCK = 6;
    localparam int BIT_TRK  = 5;
    localparam int LOW_MSB  = 4;

    typedef enum logic [0:0] {
        MODE_MANUAL = 1'b0,
        MODE_AUTO   = 1'b1
    } pbw_mode_e;

endpackage

// File: rtl/pbw_bus_decode.sv
module pbw_bus_decode #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_hit,
    output logic              rd_hit
);

    logic addr_match;

    always_comb begin
        addr_match = (bus_addr == REG_ADDR);
        wr_hit     = bus_cs && bus_we && addr_match;
        rd_hit     = bus_cs && !bus_we && addr_match;
    end

endmodule

// File: rtl/pbw_mode_fsm.sv
module pbw_mode_fsm
    import pbw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_hit,
    input  logic      wr_auto,
    output pbw_mode_e mode,
    output logic      auto_en
);

    pbw_mode_e state_q;
    pbw_mode_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_MANUAL;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: MAN_TO_AUTO, AUTO_TO_MAN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_MANUAL: if (wr_hit && wr_auto)  state_d = MODE_AUTO;
            MODE_AUTO:   if (wr_hit && !wr_auto) state_d = MODE_MANUAL;
            default:     state_d = MODE_MANUAL;
        endcase
    end

    // Outputs
    always_comb begin
        mode    = state_q;
        auto_en = 1'b0;
        unique case (state_q)
            MODE_MANUAL: auto_en = 1'b0;
            MODE_AUTO:   auto_en = 1'b1;
            default:     auto_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/pbw_shadow.sv
module pbw_shadow
    import pbw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_hit,
    input  pbw_mode_e mode,
    input  logic      wr_trk,
    output logic      trk_shadow
);

    logic shadow_q;

    // Only a manual-mode write may touch the software choice.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= 1'b0;
        end else if (wr_hit && (mode == MODE_MANUAL)) begin
            shadow_q <= wr_trk;
        end
    end

    assign trk_shadow = shadow_q;

endmodule

// File: rtl/pbw_ctrl_reg.sv
module pbw_ctrl_reg
    import pbw_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              pll_lock_i,
    input  logic              auto_trk_i,
    output logic              auto_en_o,
    output logic              trk_sel_o
);

    logic      wr_hit;
    logic      rd_hit;
    pbw_mode_e mode;
    logic      auto_en;
    logic      trk_shadow;
    logic [REG_W-1:0] reg_view;
    logic      unused_wdata;

    assign unused_wdata = ^{bus_wdata[BIT_LOCK], bus_wdata[LOW_MSB:0]};

    pbw_bus_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) dec_i (
        .bus_cs   (bus_cs),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    pbw_mode_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_auto (bus_wdata[BIT_AUTO]),
        .mode    (mode),
        .auto_en (auto_en)
    );

    pbw_shadow shd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (wr_hit),
        .mode       (mode),
        .wr_trk     (bus_wdata[BIT_TRK]),
        .trk_shadow (trk_shadow)
    );

    always_comb begin
        reg_view           = '0;
        reg_view[BIT_AUTO] = auto_en;
        reg_view[BIT_LOCK] = auto_en & pll_lock_i;
        reg_view[BIT_TRK]  = auto_en ? auto_trk_i : trk_shadow;
        bus_rdata          = rd_hit ? reg_view : '0;
        auto_en_o          = auto_en;
        trk_sel_o          = auto_en ? auto_trk_i : trk_shadow;
    end

endmodule

// File: rtl/pbw_ctrl_chk.sv
module pbw_ctrl_chk #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              pll_lock_i,
    input logic              auto_trk_i,
    input logic              auto_en_o,
    input logic              trk_sel_o
);

    logic wr_hit;
    logic rd_hit;

    assign wr_hit = bus_cs && bus_we && (bus_addr == REG_ADDR);
    assign rd_hit = bus_cs && !bus_we && (bus_addr == REG_ADDR);

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[4:0] == 5'd0); // R2
    AST_MODE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> auto_en_o == $past(bus_wdata[7])); // R3
    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(auto_en_o)); // R9
    AST_LOCK_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && auto_en_o) |-> bus_rdata[6] == pll_lock_i); // R4
    AST_LOCK_MANUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en_o |-> !bus_rdata[6]); // R4
    AST_AUTO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en_o |-> trk_sel_o == auto_trk_i); // R6
    AST_MANUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en_o && wr_hit && !bus_wdata[7]) |=> trk_sel_o == $past(bus_wdata[5])); // R7
    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en_o && !wr_hit) |=> $stable(trk_sel_o)); // R8
    AST_NO_READ_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> bus_rdata == 8'h00); // R9

endmodule

bind pbw_ctrl_reg pbw_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs     (bus_cs),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pll_lock_i (pll_lock_i),
    .auto_trk_i (auto_trk_i),
    .auto_en_o  (auto_en_o),
    .trk_sel_o  (trk_sel_o)
);

// File: tb/pbw_ctrl_reg_tb_top.sv
module pbw_ctrl_reg_tb_top;

    localparam int          AW   = 6;
    localparam logic [AW-1:0] RA = 6'h15;
    localparam logic [AW-1:0] NA = 6'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          pll_lock_i = 1'b0;
    logic          auto_trk_i = 1'b0;
    logic          auto_en_o;
    logic          trk_sel_o;

    always #5 clk = ~clk;

    pbw_ctrl_reg #(.ADDR_W(AW), .REG_ADDR(RA)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_cs     (bus_cs),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pll_lock_i (pll_lock_i),
        .auto_trk_i (auto_trk_i),
        .auto_en_o  (auto_en_o),
        .trk_sel_o  (trk_sel_o)
    );

    // kind: 0 = read data, 1 = auto enable, 2 = select
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;

    // Monitor: compares every queued expectation at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = {7'd0, auto_en_o};
                    default: act = {7'd0, trk_sel_o};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic idle_bus();
        bus_cs = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic bus_write(input logic cs, input logic we, input logic [AW-1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_cs = cs; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        idle_bus();
    endtask

    task automatic exp_read(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
        it.kind = 0; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_outs(input logic ae, input logic ts, input string tag);
        item_t it;
        @(posedge clk); #1;
        idle_bus();
        it.kind = 1; it.exp = {7'd0, ae}; it.tag = tag;
        q.push_back(it);
        it.kind = 2; it.exp = {7'd0, ts};
        q.push_back(it);
    endtask

    task automatic set_pll(input logic lk, input logic tr);
        @(posedge clk); #1;
        pll_lock_i = lk; auto_trk_i = tr;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        exp_outs(1'b0, 1'b0, "R1 reset outputs");
        exp_read(RA, 8'h00, "R1 reset read");

        // PLL flags driven high while in manual mode
        set_pll(1'b1, 1'b1);
        exp_read(RA, 8'h00, "R4 lock reads 0 in manual");
        exp_outs(1'b0, 1'b0, "R7 manual select ignores status flag");

        bus_write(1'b1, 1'b1, RA, 8'h20);
        exp_outs(1'b0, 1'b1, "R7 manual write tracking");
        exp_read(RA, 8'h20, "R7 manual readback");

        bus_write(1'b1, 1'b1, RA, 8'h60);
        exp_read(RA, 8'h20, "R5 lock write ignored");
        bus_write(1'b1, 1'b1, RA, 8'h3F);
        exp_read(RA, 8'h20, "R2 low bits read 0");

        // Non-matching bus cycles
        bus_write(1'b1, 1'b1, NA, 8'h80);
        exp_outs(1'b0, 1'b1, "R9 wrong address write");
        bus_write(1'b0, 1'b1, RA, 8'h80);
        exp_outs(1'b0, 1'b1, "R9 write without select");
        bus_write(1'b1, 1'b0, RA, 8'h80);
        exp_outs(1'b0, 1'b1, "R9 read cycle does not write");
        exp_read(NA, 8'h00, "R9 read other address");

        // Enter automatic mode while keeping tracking stored
        set_pll(1'b0, 1'b0);
        bus_write(1'b1, 1'b1, RA, 8'hA0);
        exp_outs(1'b1, 1'b0, "R3 auto set / R6 select follows status");
        exp_read(RA, 8'h80, "R6 auto view acquisition unlocked");
        set_pll(1'b1, 1'b1);
        exp_read(RA, 8'hE0, "R4 lock visible in auto");
        exp_outs(1'b1, 1'b1, "R6 select follows status");

        bus_write(1'b1, 1'b1, RA, 8'h80);
        bus_write(1'b1, 1'b1, RA, 8'hDF);
        set_pll(1'b0, 1'b0);
        exp_read(RA, 8'h80, "R8 auto writes leave view on status");

        bus_write(1'b1, 1'b1, RA, 8'h00);
        exp_outs(1'b0, 1'b1, "R8 restore tracking after auto");
        exp_read(RA, 8'h20, "R8 restored readback");

        // Second episode: enter with acquisition stored
        bus_write(1'b1, 1'b1, RA, 8'h80);
        set_pll(1'b1, 1'b1);
        exp_outs(1'b1, 1'b1, "R3 auto set second episode");
        bus_write(1'b1, 1'b1, RA, 8'hA0);
        bus_write(1'b1, 1'b1, RA, 8'h00);
        exp_outs(1'b0, 1'b0, "R8 restore acquisition after auto");
        exp_read(RA, 8'h00, "R8 restored acquisition readback");

        // Reset in the middle of automatic mode
        bus_write(1'b1, 1'b1, RA, 8'hA0);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        exp_outs(1'b0, 1'b0, "R1 reset from auto");
        exp_read(RA, 8'h00, "R1 reset read from auto");

        @(posedge clk); #1 idle_bus();
        @(negedge clk);
        @(posedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule